// File: doc/BRIEF.md
# Memory-Mapped Serial Port Register Front End

This block sits between a 32-bit register bus and a pair of byte streams. It holds the registers of a serial port and nothing below them: no bit timing, no baud divider, no DMA engine. Bytes offered on the incoming stream are queued in a 16-entry receive FIFO. A write to the data-out word sends one byte on the outgoing stream. Software sees the receive side through a combined status-and-data word, which it can read either as a peek that leaves the FIFO untouched or as a pop that consumes the oldest byte.

Interrupts come from a raw status word. A mask selects which raw bits drive the single interrupt line, and an acknowledge word clears raw bits. Raw bit 3 follows the receive FIFO's fill state. Bits 1:0 are raised by a transmit. The first acknowledge after a transmit is altered so that raw bit 0 survives it once. The transmit control, transmit DMA enable and receive control words are plain storage, apart from the receive enable in bit 3 of receive control.

Top module: `mmio_serial_port`

## Requirements
- R1: After reset, receive control (byte offset 0x08) reads 0x00010000 and every other stored word reads 0. `rx_ready`, `irq` and `tx_valid` are low.
- R2: `rx_ready` is high exactly when receive-control bit 3 is 1 and the FIFO holds fewer than 16 bytes. A byte is taken only on a cycle where `rx_valid` and `rx_ready` are both high.
- R3: The FIFO holds 16 bytes and returns them oldest first. An offer made while it is full is not taken and leaves its contents unchanged.
- R4: A status read at 0x20 or 0x24 returns the following word. Bits 7:0 hold the oldest byte. When the FIFO is empty, bits 7:0 hold the slot the next arrival will fill. Bit 16 is 1 when the FIFO is non-empty, bits 22 and 24 are always 1, and all other bits are 0.
- R5: A read at 0x24 never changes the FIFO. A read at 0x20 removes the oldest byte if there is one, and does nothing to an empty FIFO.
- R6: A pop read and an accepted byte in the same cycle leave the fill count unchanged and keep the byte order.
- R7: Raw interrupt bit 3 takes the value "FIFO non-empty after this cycle" only on a cycle with a register write or an accepted byte. A pop alone leaves it unchanged.
- R8: A write to 0x1C drives its low byte on `tx_data` with `tx_valid` high for exactly the next cycle. It stores the full word, readable at 0x1C, and sets raw bits 1:0.
- R9: A write to 0x30 stores the value, readable at 0x30, and clears each raw bit (0x34) that is 1 in that value. Bit 3 is then re-evaluated per R7.
- R10: If a data-out write happened since the last acknowledge, the next acknowledge has bit 0 forced to 0 in both the stored value and the clear. Later acknowledges are used unchanged.
- R11: Offset 0x38 reads raw AND mask (mask at 0x2C). `irq` is high whenever that word is non-zero.
- R12: Writing 0x34 loads the raw word directly, subject to bit-3 re-evaluation. The other stored words (0x00–0x18, 0x28) read back what was written. Offset 0x3C reads 0, and writes to 0x20, 0x24, 0x38 and 0x3C are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read strobe; pop reads take effect at the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from `bus_addr` |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | CHAR_W | Incoming byte |
| rx_ready | output | 1 | FIFO can take a byte |
| tx_valid | output | 1 | One-cycle pulse carrying an outgoing byte |
| tx_data | output | CHAR_W | Outgoing byte |
| irq | output | 1 | Level interrupt, OR of masked raw bits |

## Verification
The bench fills the FIFO and keeps offering bytes past 16. A design that took them would overwrite the oldest entry and shift every later peek. It pops and pushes in the same cycle, where a count that did not net the two would drift. It pops the FIFO empty and checks that raw bit 3 and `irq` stay high until the next write; a design that tracked the count continuously would drop them early. It runs two acknowledges of 0xFF after a transmit. A design without the one-shot fixup would clear bit 0 on the first one, and one that never released the fixup would leave bit 0 set after the second.

// File: rtl/msp_pkg.sv
package msp_pkg;
   // word indices (byte offset / 4)
   localparam int unsigned W_RXCTL  = 2;
   localparam int unsigned W_DOUT   = 7;
   localparam int unsigned W_POP    = 8;
   localparam int unsigned W_PEEK   = 9;
   localparam int unsigned W_MASK   = 11;
   localparam int unsigned W_ACK    = 12;
   localparam int unsigned W_RAW    = 13;
   localparam int unsigned W_MASKED = 14;

   localparam int unsigned ST_AVAIL_BIT = 16;
   localparam int unsigned ST_IDLE_BIT  = 22;
   localparam int unsigned ST_READY_BIT = 24;
   localparam int unsigned RXEN_BIT     = 3;
   localparam int unsigned IRQ_RXNE_BIT = 3;

   localparam logic [31:0] RXCTL_INIT = 32'h0001_0000;

   // words held as plain storage in the register file
   function automatic bit is_plain(int unsigned w);
      return (w <= 7) || (w == 10) || (w == W_MASK);
   endfunction
endpackage

// File: rtl/msp_regfile.sv
module msp_regfile #(
   parameter int unsigned NW = 16,
   parameter int unsigned DW = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NW-1:0]          wr_en,
   input  logic [DW-1:0]          wdata,
   output logic [NW-1:0][DW-1:0]  q
);
   for (genvar g = 0; g < NW; g++) begin : g_word
      if (msp_pkg::is_plain(g)) begin : g_store
         localparam logic [DW-1:0] INIT =
            (g == msp_pkg::W_RXCTL) ? DW'(msp_pkg::RXCTL_INIT) : '0;
         logic [DW-1:0] r;
         always_ff @(posedge clk) begin
            if (!rst_n)        r <= INIT;
            else if (wr_en[g]) r <= wdata;
         end
         assign q[g] = r;
      end else begin : g_none
         logic unused_we;
         assign unused_we = wr_en[g];
         assign q[g] = '0;
      end
   end
endmodule

// File: rtl/msp_rx_fifo.sv
module msp_rx_fifo #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned W     = 8,
   localparam int unsigned PW   = $clog2(DEPTH),
   localparam int unsigned CW   = PW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop_req,
   output logic [W-1:0]  head,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          nonempty_next
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("msp_rx_fifo: DEPTH must be a power of two >= 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp;
   logic [CW-1:0] cnt, cnt_nxt;
   logic          pop_eff;

   assign pop_eff       = pop_req && (cnt != '0);
   assign cnt_nxt       = cnt + CW'(push) - CW'(pop_eff);
   assign nonempty_next = (cnt_nxt != '0);
   assign count         = cnt;
   assign full          = (cnt == CW'(DEPTH));
   assign head          = mem[wp - cnt[PW-1:0]];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         cnt <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (push) begin
            mem[wp] <= din;
            wp      <= wp + 1'b1;
         end
         cnt <= cnt_nxt;
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH)); // R3
   AST_PUSH_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full); // R3
   AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && count == '0 && !push) |=> count == '0); // R5
endmodule

// File: rtl/msp_irq_ctrl.sv
module msp_irq_ctrl #(
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_dout,
   input  logic          wr_ack,
   input  logic          wr_raw,
   input  logic [DW-1:0] wdata,
   input  logic          reeval,
   input  logic          rxne_next,
   input  logic [DW-1:0] mask,
   output logic [DW-1:0] raw,
   output logic [DW-1:0] ack_val,
   output logic [DW-1:0] masked,
   output logic          irq
);
   logic [DW-1:0] raw_q, raw_d, ack_q, ack_d, ackv;
   logic          pend_q, pend_d;

   always_comb begin
      raw_d  = raw_q;
      ack_d  = ack_q;
      pend_d = pend_q;
      ackv   = wdata;
      if (wr_dout) begin
         raw_d[1:0] = 2'b11;
         pend_d     = 1'b1;
      end
      if (wr_ack) begin
         if (pend_q) begin
            ackv[0] = 1'b0;
            pend_d  = 1'b0;
         end
         ack_d = ackv;
         raw_d = raw_d & ~ackv;
      end
      if (wr_raw) raw_d = wdata;
      if (reeval) raw_d[msp_pkg::IRQ_RXNE_BIT] = rxne_next;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         raw_q  <= '0;
         ack_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         raw_q  <= raw_d;
         ack_q  <= ack_d;
         pend_q <= pend_d;
      end
   end

   assign raw     = raw_q;
   assign ack_val = ack_q;
   assign masked  = raw_q & mask;
   assign irq     = |masked;

   AST_TX_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dout |=> raw[1:0] == 2'b11); // R8
   AST_ACK_FIXUP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ack && pend_q) |=> (!ack_val[0] && !pend_q)); // R10
   AST_RXNE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      reeval |=> raw[msp_pkg::IRQ_RXNE_BIT] == $past(rxne_next)); // R7
   AST_RXNE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!reeval && !wr_raw) |=> $stable(raw[msp_pkg::IRQ_RXNE_BIT])); // R7
endmodule

// File: rtl/mmio_serial_port.sv
module mmio_serial_port #(
   parameter int unsigned ADDR_W     = 6,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned CHAR_W     = 8,
   parameter int unsigned FIFO_DEPTH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              rx_valid,
   input  logic [CHAR_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              tx_valid,
   output logic [CHAR_W-1:0] tx_data,
   output logic              irq
);
   import msp_pkg::*;

   localparam int unsigned IDX_W = ADDR_W - 2;
   localparam int unsigned NW    = 1 << IDX_W;
   localparam int unsigned CW    = $clog2(FIFO_DEPTH) + 1;

   if (DATA_W != 32)  begin : g_bad_dw   $error("DATA_W must be 32"); end
   if (ADDR_W < 6)    begin : g_bad_aw   $error("ADDR_W must be >= 6"); end
   if (CHAR_W > 16)   begin : g_bad_cw   $error("CHAR_W must be <= 16"); end

   logic [IDX_W-1:0]            idx;
   logic [NW-1:0]               wr_hit;
   logic [NW-1:0][DATA_W-1:0]   regs;
   logic                        rx_en, push, pop_req, fifo_full, rxne_next;
   logic [CHAR_W-1:0]           head;
   logic [CW-1:0]               fifo_cnt;
   logic [DATA_W-1:0]           raw, ack_val, masked, stat;
   logic                        unused_addr;

   assign unused_addr = ^bus_addr[1:0];
   assign idx     = bus_addr[ADDR_W-1:2];
   assign wr_hit  = bus_wr ? (NW'(1) << idx) : '0;
   assign rx_en   = regs[W_RXCTL][RXEN_BIT];
   assign rx_ready = rx_en && !fifo_full;
   assign push    = rx_valid && rx_ready;
   assign pop_req = bus_rd && (idx == IDX_W'(W_POP));

   msp_regfile #(.NW(NW), .DW(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_hit), .wdata(bus_wdata), .q(regs));

   msp_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(CHAR_W)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .din(rx_data), .pop_req(pop_req),
      .head(head), .count(fifo_cnt), .full(fifo_full), .nonempty_next(rxne_next));

   msp_irq_ctrl #(.DW(DATA_W)) u_irq (
      .clk(clk), .rst_n(rst_n),
      .wr_dout(wr_hit[W_DOUT]), .wr_ack(wr_hit[W_ACK]), .wr_raw(wr_hit[W_RAW]),
      .wdata(bus_wdata), .reeval(bus_wr || push), .rxne_next(rxne_next),
      .mask(regs[W_MASK]), .raw(raw), .ack_val(ack_val), .masked(masked), .irq(irq));

   always_comb begin
      stat = '0;
      stat[CHAR_W-1:0]   = head;
      stat[ST_AVAIL_BIT] = (fifo_cnt != '0);
      stat[ST_IDLE_BIT]  = 1'b1;
      stat[ST_READY_BIT] = 1'b1;
   end

   always_comb begin
      case (idx)
         IDX_W'(W_POP), IDX_W'(W_PEEK): bus_rdata = stat;
         IDX_W'(W_ACK):                 bus_rdata = ack_val;
         IDX_W'(W_RAW):                 bus_rdata = raw;
         IDX_W'(W_MASKED):              bus_rdata = masked;
         default:                       bus_rdata = regs[idx];
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_valid <= 1'b0;
         tx_data  <= '0;
      end else begin
         tx_valid <= wr_hit[W_DOUT];
         if (wr_hit[W_DOUT]) tx_data <= bus_wdata[CHAR_W-1:0];
      end
   end

   AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_ready && !pop_req) |=> $stable(fifo_cnt)); // R2
   AST_TX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> $past(wr_hit[W_DOUT])); // R8
endmodule

// File: tb/mmio_serial_port_tb.sv
module mmio_serial_port_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_rd = 1'b0, bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_ready, tx_valid, irq;
   logic [7:0]  tx_data;

   int checks = 0, fails = 0;
   bit done = 0;

   always #10 clk = ~clk;  // 50 MHz

   mmio_serial_port dut_i (
      .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
      .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq));

   // ---------------- reference model ----------------
   logic [31:0] m_regs [16];
   logic [31:0] m_raw, m_ack;
   logic [7:0]  m_mem [16];
   int          m_wp, m_cnt;
   bit          m_pend, m_txv;
   logic [7:0]  m_txd;

   function automatic bit m_ready();
      return m_regs[2][3] && (m_cnt < 16);
   endfunction

   function automatic logic [31:0] exp_rd(int i);
      logic [31:0] s;
      case (i)
         8, 9: begin
            s = 32'h0140_0000;
            s[7:0] = m_mem[(m_wp - m_cnt) & 15];
            s[16]  = (m_cnt != 0);
            return s;
         end
         12: return m_ack;
         13: return m_raw;
         14: return m_raw & m_regs[11];
         15: return 32'h0;
         default: return m_regs[i];
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) begin m_regs[i] = '0; m_mem[i] = '0; end
         m_regs[2] = 32'h0001_0000;
         m_raw = '0; m_ack = '0; m_wp = 0; m_cnt = 0;
         m_pend = 0; m_txv = 0; m_txd = '0;
      end else begin
         automatic bit acc  = rx_valid && m_ready();
         automatic int i    = int'(bus_addr[5:2]);
         automatic bit popd = bus_rd && i == 8 && m_cnt > 0;
         automatic logic [31:0] v;
         if (acc) begin m_mem[m_wp] = rx_data; m_wp = (m_wp + 1) % 16; end
         m_cnt = m_cnt + int'(acc) - int'(popd);
         m_txv = 0;
         if (bus_wr) begin
            case (i)
               7: begin
                  m_regs[7] = bus_wdata; m_raw[1:0] = 2'b11; m_pend = 1;
                  m_txv = 1; m_txd = bus_wdata[7:0];
               end
               12: begin
                  v = bus_wdata;
                  if (m_pend) begin v[0] = 1'b0; m_pend = 0; end
                  m_ack = v; m_raw = m_raw & ~v;
               end
               13: m_raw = bus_wdata;
               8, 9, 14, 15: ;
               default: m_regs[i] = bus_wdata;
            endcase
         end
         if (bus_wr || acc) m_raw[3] = (m_cnt != 0);
      end
   end

   // ---------------- per-cycle output comparison ----------------
   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(rx_ready == m_ready(), "R2 rx_ready", 32'(rx_ready), 32'(m_ready()));
         chk(irq == |(m_raw & m_regs[11]), "R11 irq", 32'(irq), 32'(|(m_raw & m_regs[11])));
         chk(tx_valid == m_txv, "R8 tx_valid", 32'(tx_valid), 32'(m_txv));
         if (m_txv) chk(tx_data == m_txd, "R8 tx_data", 32'(tx_data), 32'(m_txd));
      end
   end

   // ---------------- stimulus tasks ----------------
   task automatic wr(int i, logic [31:0] v);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 6'(i << 2); bus_wdata = v;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   // optional read at word i plus optional byte offer, one cycle
   task automatic cyc(bit rd, int i, bit push, logic [7:0] d, string tag);
      @(negedge clk);
      bus_rd = rd; bus_addr = 6'(i << 2);
      rx_valid = push; rx_data = d;
      #2;
      if (rd) chk(bus_rdata == exp_rd(i), tag, bus_rdata, exp_rd(i));
      @(posedge clk); #1;
      bus_rd = 1'b0; rx_valid = 1'b0;
   endtask

   task automatic rd(int i, string tag);
      cyc(1'b1, i, 1'b0, 8'h00, tag);
   endtask

   task automatic offer(logic [7:0] d);
      cyc(1'b0, 0, 1'b1, d, "");
   endtask

   initial begin
      #(20 * 100000);
      fails++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset values of every word
      for (int i = 0; i < 16; i++) rd(i, "R1 reset word");

      // R2: receiver disabled, byte not taken
      offer(8'h11);
      rd(9, "R2 no accept while disabled");

      // enable receiver; stale bit3 and mask
      wr(2, 32'h0000_0008);
      wr(11, 32'h0000_0008);
      offer(8'hA1); offer(8'hA2); offer(8'hA3);
      rd(9, "R5 peek once"); rd(9, "R5 peek twice");
      rd(8, "R4 pop first"); rd(8, "R5 pop second");
      rd(13, "R7 raw bit3 after pops");
      rd(8, "R4 pop last");
      rd(13, "R7 raw bit3 stale after pop");
      rd(8, "R5 pop on empty");
      rd(9, "R4 empty status word");
      wr(10, 32'h1234_5678);
      rd(13, "R7 raw bit3 after write");
      rd(10, "R12 plain storage");

      // R3: fill past capacity
      for (int k = 0; k < 20; k++) offer(8'(8'h40 + k));
      rd(9, "R3 oldest kept when full");
      rd(14, "R11 masked view");
      for (int k = 0; k < 4; k++) rd(8, "R3 order after full");

      // R6: pop and push together
      cyc(1'b1, 8, 1'b1, 8'hC6, "R6 pop with push");
      cyc(1'b1, 8, 1'b1, 8'hC7, "R6 pop with push again");
      for (int k = 0; k < 16; k++) rd(8, "R6 drain order");
      rd(9, "R6 empty after drain");

      // R8, R10, R9: transmit and acknowledge
      wr(11, 32'h0000_000B);
      wr(7, 32'hDEAD_BE5A);
      rd(7, "R8 stored data-out word");
      rd(13, "R8 raw flags");
      wr(12, 32'h0000_00FF);
      rd(12, "R10 first ack fixed up");
      rd(13, "R10 raw bit0 kept");
      wr(12, 32'h0000_00FF);
      rd(12, "R9 second ack stored");
      rd(13, "R10 raw bit0 cleared");
      wr(7, 32'h0000_0033);
      wr(12, 32'h0000_0002);
      rd(13, "R9 partial ack");
      rd(12, "R10 fixup on partial ack");

      // R12: raw write, ignored addresses
      wr(13, 32'hF0F0_00F7);
      rd(13, "R12 raw written, bit3 reevaluated");
      rd(14, "R11 masked after raw write");
      wr(15, 32'hFFFF_FFFF); rd(15, "R12 top word reads 0");
      wr(14, 32'hFFFF_FFFF); rd(14, "R12 masked not writable");
      wr(9, 32'h0000_0000);  rd(9, "R12 status write ignored");
      wr(0, 32'hCAFE_0001);  rd(0, "R12 tx control storage");
      wr(2, 32'h0000_0000);
      offer(8'h77);
      rd(9, "R2 disabled again");

      repeat (2) @(negedge clk);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule